// File: doc/BRIEF.md
# Dual-Channel Indirect Register Front-End

This block is the byte-wide bus slave of a two-channel serial controller. Each channel keeps sixteen write registers and sixteen read registers. The bus reaches them through a per-channel register pointer rather than through direct addresses. Two address bits choose the channel and choose control or data access, so the whole device uses four bus locations.

A control write while a channel's pointer is zero is a pointer command. Any other control access touches the register the pointer names, and afterwards the pointer returns to zero by itself. Registers 8 to 15 are reached through a "point high" command. A shared reset field can reset one channel or both.

Data writes hand a byte to the transmitter of the channel and raise a transmit-interrupt strobe. Receive bytes are offered through a valid/ready handshake and are read back through data reads. Interrupt prioritisation, baud generation and the serialiser live elsewhere. This block only marks events with strobes.

Top module: `sr_regfront`

## Requirements
- R1: After reset, for both channels, a read of status register 0 returns 0x44 and a read of register 1 returns 0x07. After reset, `rx_ready` is 0, transmit is disabled and both pointers are 0.
- R2: With `SWAP_SEL`=0, `addr[0]` chooses the access type (0 = control, 1 = data) and `addr[1]` chooses the channel. Channel index 1 is channel A and index 0 is channel B. Each channel's registers are independent.
- R3: A control write while the pointer is 0 loads the pointer from bits 2:0. If the command field in bits 5:3 equals 1, 8 is added to the new pointer. Without that command, registers 8 to 15 are not reached.
- R4: A control write while the pointer is nonzero stores the byte in the addressed write register and returns the pointer to 0. A control read returns the addressed read register on `rdata` in the cycle after `rd_en` and returns the pointer to 0. Read registers that are never loaded read as 0.
- R5: A write to write register 9 with bits 7:6 set to 01 resets channel B, 10 resets channel A, and 11 resets both channels. A reset restores the R1 state of the affected channels and clears any held receive byte. When a reset is taken the byte is not stored. When bits 7:6 are 00 the byte is stored and nothing is reset.
- R6: Bytes written to write registers 12 and 13 read back from read registers 12 and 13 of the same channel.
- R7: A data write sets read register 0 bit 2 and read register 1 bit 0, and pulses that channel's `txint_stb` for one cycle. It pulses `tx_valid` with the byte on `tx_data` only when write register 5 bit 3 is set.
- R8: `rx_ready` of a channel is 1 only when write register 3 bit 0 is set and read register 0 bit 0 is clear. An accepted byte sets read register 0 bit 0 and pulses `rxint_stb`. A data read returns the held byte and clears bit 0.
- R9: With `SWAP_SEL`=1, `addr[0]` chooses the channel and `addr[1]` chooses the access type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe (takes priority over rd_en) |
| addr | input | 2 | Channel and access-type select |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after rd_en |
| rx_valid | input | 2 | Receive byte offered, one bit per channel |
| rx_data | input | 16 | Receive bytes, channel i in bits 8i+7:8i |
| rx_ready | output | 2 | Channel can accept a receive byte |
| tx_valid | output | 2 | One-cycle transmit byte pulse per channel |
| tx_data | output | 16 | Transmit bytes, channel i in bits 8i+7:8i |
| txint_stb | output | 2 | Transmit-interrupt event strobe |
| rxint_stb | output | 2 | Receive-interrupt event strobe |

## Verification
The hardest state to reach from the ports is a channel holding an unread receive byte while another access resets it through the shared register 9. The same holds for a reset written through the other channel's pointer. The stimulus first enables reception and fills the holding register. It then issues the two-step pointer sequence that writes the reset field, and reads status and readiness back through the normal control path.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int NCH  = 2;
    localparam int NREG = 16;
    localparam int DW   = 8;
    localparam int PW   = $clog2(NREG);

    localparam int WR_RXCFG = 3;
    localparam int WR_FMT   = 4;
    localparam int WR_TXCFG = 5;
    localparam int WR_RST   = 9;
    localparam int WR_CLKS  = 11;
    localparam int WR_DIVLO = 12;
    localparam int WR_DIVHI = 13;
    localparam int WR_MISC  = 14;
    localparam int WR_EXTEN = 15;
    localparam int RR_STAT  = 0;
    localparam int RR_SPEC  = 1;

    typedef logic [NREG-1:0][DW-1:0] chan_regs_t;

    typedef struct packed {
        logic [NCH-1:0][NREG-1:0][DW-1:0] wr;
        logic [NCH-1:0][NREG-1:0][DW-1:0] rr;
        logic [NCH-1:0][PW-1:0]           ptr;
        logic [NCH-1:0][DW-1:0]           rxh;
        logic [DW-1:0]                    rdata;
        logic [NCH-1:0]                   tx_v;
        logic [NCH-1:0][DW-1:0]           tx_d;
        logic [NCH-1:0]                   txint;
        logic [NCH-1:0]                   rxint;
    } sr_state_t;

    function automatic chan_regs_t wr_default();
        chan_regs_t w;
        w = '0;
        w[WR_FMT]   = 8'h04;
        w[WR_RST]   = 8'hC0;
        w[WR_CLKS]  = 8'h08;
        w[WR_MISC]  = 8'h30;
        w[WR_EXTEN] = 8'hF8;
        return w;
    endfunction

    function automatic chan_regs_t rr_default();
        chan_regs_t r;
        r = '0;
        r[RR_STAT] = 8'h44;
        r[RR_SPEC] = 8'h07;
        return r;
    endfunction

    function automatic sr_state_t reset_state();
        sr_state_t s;
        s = '0;
        for (int i = 0; i < NCH; i++) begin
            s.wr[i] = wr_default();
            s.rr[i] = rr_default();
        end
        return s;
    endfunction
endpackage

// File: rtl/sr_addr_map.sv
module sr_addr_map #(
    parameter bit SWAP = 1'b0
) (
    input  logic [1:0] addr,
    output logic       is_data,
    output logic       chan
);
    generate
        if (SWAP) begin : g_swapped
            assign is_data = addr[1];
            assign chan    = addr[0];
        end else begin : g_normal
            assign is_data = addr[0];
            assign chan    = addr[1];
        end
    endgenerate
endmodule

// File: rtl/sr_rx_gate.sv
module sr_rx_gate (
    input  logic rx_en,
    input  logic rx_full,
    input  logic rx_valid,
    output logic ready,
    output logic take
);
    assign ready = rx_en && !rx_full;
    assign take  = ready && rx_valid;
endmodule

// File: rtl/sr_regfront.sv
module sr_regfront
    import sr_pkg::*;
#(
    parameter bit SWAP_SEL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [1:0]    rx_valid,
    input  logic [15:0]   rx_data,
    output logic [1:0]    rx_ready,
    output logic [1:0]    tx_valid,
    output logic [15:0]   tx_data,
    output logic [1:0]    txint_stb,
    output logic [1:0]    rxint_stb
);
    localparam logic [2:0] CMD_POINT_HI = 3'd1;

    sr_state_t q, d;
    logic            is_data;
    logic            ch;
    logic [NCH-1:0]  take;
    logic [NCH-1:0]  rst_mask;
    logic [PW-1:0]   cur_ptr;

    sr_addr_map #(.SWAP(SWAP_SEL)) u_map (
        .addr    (addr),
        .is_data (is_data),
        .chan    (ch)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_rx
        sr_rx_gate u_gate (
            .rx_en    (q.wr[i][WR_RXCFG][0]),
            .rx_full  (q.rr[i][RR_STAT][0]),
            .rx_valid (rx_valid[i]),
            .ready    (rx_ready[i]),
            .take     (take[i])
        );
    end

    assign cur_ptr = q.ptr[ch];

    always_comb begin
        d          = q;
        d.tx_v     = '0;
        d.txint    = '0;
        d.rxint    = '0;
        rst_mask   = '0;
        if (wr_en) begin
            if (!is_data) begin
                if (cur_ptr == '0) begin
                    d.ptr[ch] = {(wdata[5:3] == CMD_POINT_HI), wdata[2:0]};
                end else begin
                    d.ptr[ch] = '0;
                    if (cur_ptr == PW'(WR_RST) && wdata[7:6] != 2'b00) begin
                        rst_mask = wdata[7:6];
                    end else begin
                        d.wr[ch][cur_ptr] = wdata;
                        if (cur_ptr == PW'(WR_DIVLO) || cur_ptr == PW'(WR_DIVHI))
                            d.rr[ch][cur_ptr] = wdata;
                    end
                end
            end else begin
                d.rr[ch][RR_STAT][2] = 1'b1;
                d.rr[ch][RR_SPEC][0] = 1'b1;
                d.txint[ch]          = 1'b1;
                if (q.wr[ch][WR_TXCFG][3]) begin
                    d.tx_v[ch] = 1'b1;
                    d.tx_d[ch] = wdata;
                end
            end
        end else if (rd_en) begin
            if (!is_data) begin
                d.rdata   = q.rr[ch][cur_ptr];
                d.ptr[ch] = '0;
            end else begin
                d.rdata              = q.rxh[ch];
                d.rr[ch][RR_STAT][0] = 1'b0;
            end
        end
        for (int i = 0; i < NCH; i++) begin
            if (take[i]) begin
                d.rxh[i]             = rx_data[DW*i +: DW];
                d.rr[i][RR_STAT][0]  = 1'b1;
                d.rxint[i]           = 1'b1;
            end
        end
        for (int i = 0; i < NCH; i++) begin
            if (rst_mask[i]) begin
                d.wr[i]    = wr_default();
                d.rr[i]    = rr_default();
                d.ptr[i]   = '0;
                d.rxh[i]   = '0;
                d.rxint[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= reset_state();
        else        q <= d;
    end

    assign rdata     = q.rdata;
    assign tx_valid  = q.tx_v;
    assign tx_data   = q.tx_d;
    assign txint_stb = q.txint;
    assign rxint_stb = q.rxint;
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
    parameter bit SWAP = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [1:0] rx_valid,
    input logic [1:0] rx_ready,
    input logic [1:0] tx_valid,
    input logic [1:0] txint_stb,
    input logic [1:0] rxint_stb
);
    logic dsel, csel;
    assign dsel = SWAP ? addr[1] : addr[0];
    assign csel = SWAP ? addr[0] : addr[1];

    // R7: at most one channel transmits per cycle
    p_txone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_valid));

    for (genvar i = 0; i < 2; i++) begin : g_ch
        // R7: every data write raises the transmit strobe next cycle
        p_txint_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && dsel && csel == i) |=> txint_stb[i]);
        // R7: a transmit pulse only follows a data write to that channel
        p_txsrc_r7: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid[i] |-> $past(wr_en && dsel && csel == i));
        // R8: an accepted byte blocks the next one
        p_rxtake_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[i] && rx_ready[i] && !wr_en) |=> !rx_ready[i]);
        // R8: receive strobe only after an accepted byte
        p_rxint_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rxint_stb[i] |-> $past(rx_valid[i] && rx_ready[i]));
    end
endmodule

bind sr_regfront sr_checker #(.SWAP(SWAP_SEL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .txint_stb (txint_stb),
    .rxint_stb (rxint_stb)
);

// File: tb/tb_sr_regfront.sv
module tb_sr_regfront;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [1:0]  rx_valid = '0;
    logic [15:0] rx_data = '0;
    logic [1:0]  rx_ready, tx_valid, txint_stb, rxint_stb;
    logic [15:0] tx_data;

    logic        rd2 = 1'b0, wr2 = 1'b0;
    logic [7:0]  rdata2;
    logic [1:0]  rdy2, txv2, txi2, rxi2;
    logic [15:0] txd2;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    sr_regfront #(.SWAP_SEL(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .txint_stb(txint_stb), .rxint_stb(rxint_stb)
    );

    sr_regfront #(.SWAP_SEL(1'b1)) dut_swp (
        .clk(clk), .rst_n(rst_n), .rd_en(rd2), .wr_en(wr2), .addr(addr),
        .wdata(wdata), .rdata(rdata2), .rx_valid(2'b00), .rx_data(16'h0),
        .rx_ready(rdy2), .tx_valid(txv2), .tx_data(txd2),
        .txint_stb(txi2), .rxint_stb(rxi2)
    );

    // scoreboard queues
    logic [7:0] rd_exp_q[$];
    string      rd_tag_q[$];
    logic [8:0] tx_exp_q[$];
    logic       rd_seen = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= rd_en && rst_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (rd_exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected read", rdata, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = rd_exp_q.pop_front();
                t = rd_tag_q.pop_front();
                chk(rdata == e, t, rdata, e);
            end
        end
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                if (tx_valid[c]) begin
                    if (tx_exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected tx", {c[0], tx_data[8*c +: 8]}, 0);
                    end else begin
                        logic [8:0] e;
                        e = tx_exp_q.pop_front();
                        chk(e == {c[0], tx_data[8*c +: 8]}, "R7 tx byte",
                            {c[0], tx_data[8*c +: 8]}, e);
                    end
                end
            end
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        rd_exp_q.push_back(e);
        rd_tag_q.push_back(tag);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // R2: control = {ch,0}, data = {ch,1}
    task automatic wreg(input bit c, input int r, input logic [7:0] v);
        if (r >= 8) bus_wr({c, 1'b0}, 8'h08 | 8'(r & 7));
        else        bus_wr({c, 1'b0}, 8'(r));
        bus_wr({c, 1'b0}, v);
    endtask

    task automatic rreg(input bit c, input int r, input logic [7:0] e, input string tag);
        if (r >= 8)      bus_wr({c, 1'b0}, 8'h08 | 8'(r & 7));
        else if (r != 0) bus_wr({c, 1'b0}, 8'(r));
        bus_rd({c, 1'b0}, e, tag);
    endtask

    task automatic offer(input bit c, input logic [7:0] v);
        @(negedge clk); rx_valid[c] = 1'b1; rx_data[8*c +: 8] = v;
        @(negedge clk); rx_valid = '0;
    endtask

    initial begin
        #(CLK_PER * 50000);
        chk(1'b0, "watchdog", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(rx_ready == 2'b00, "R1 rx_ready", rx_ready, 0);
        rreg(0, 0, 8'h44, "R1 B RR0");
        rreg(0, 1, 8'h07, "R1 B RR1");
        rreg(1, 0, 8'h44, "R1 A RR0");
        rreg(1, 1, 8'h07, "R1 A RR1");

        // R6 mirror, R2 channel isolation
        wreg(1, 12, 8'h5A);
        wreg(1, 13, 8'hA5);
        rreg(1, 12, 8'h5A, "R6 RR12");
        rreg(1, 13, 8'hA5, "R6 RR13");
        rreg(0, 12, 8'h00, "R2 channel isolation");

        // R3/R4 pointer protocol
        bus_wr(2'b10, 8'h0C);
        bus_wr(2'b10, 8'h66);
        bus_rd(2'b10, 8'h44, "R4 pointer back after write");
        rreg(1, 12, 8'h66, "R3 point high");
        bus_rd(2'b10, 8'h44, "R4 pointer back after read");
        bus_wr(2'b10, 8'h04);
        bus_wr(2'b10, 8'h99);
        rreg(1, 12, 8'h66, "R3 no point high");
        rreg(1, 2, 8'h00, "R4 unloaded reads zero");

        // R5 resets
        wreg(0, 12, 8'h21);
        wreg(1, 9, 8'h00);
        rreg(0, 12, 8'h21, "R5 no reset B");
        rreg(1, 12, 8'h66, "R5 no reset A");
        wreg(1, 9, 8'h40);
        rreg(0, 12, 8'h00, "R5 B reset");
        rreg(1, 12, 8'h66, "R5 A kept");
        wreg(0, 12, 8'h21);
        wreg(0, 9, 8'h80);
        rreg(1, 12, 8'h00, "R5 A reset");
        rreg(0, 12, 8'h21, "R5 B kept");
        wreg(1, 12, 8'h66);
        wreg(1, 9, 8'hC0);
        rreg(0, 12, 8'h00, "R5 both B");
        rreg(1, 12, 8'h00, "R5 both A");

        // R7 transmit
        bus_wr(2'b11, 8'h3C);
        chk(txint_stb == 2'b10, "R7 txint disabled tx", txint_stb, 2);
        wreg(1, 5, 8'h08);
        tx_exp_q.push_back({1'b1, 8'h3C});
        bus_wr(2'b11, 8'h3C);
        chk(txint_stb == 2'b10, "R7 txint", txint_stb, 2);
        bus_wr(2'b01, 8'h55);
        chk(txint_stb == 2'b01, "R7 txint B", txint_stb, 1);
        rreg(1, 0, 8'h44, "R7 RR0");
        rreg(1, 1, 8'h07, "R7 RR1");
        chk(tx_exp_q.size() == 0, "R7 tx delivered", tx_exp_q.size(), 0);

        // R8 receive
        chk(rx_ready[1] == 1'b0, "R8 disabled", rx_ready[1], 0);
        offer(1, 8'h77);
        chk(rxint_stb == 2'b00, "R8 no take disabled", rxint_stb, 0);
        rreg(1, 0, 8'h44, "R8 RR0 unchanged");
        wreg(1, 3, 8'h01);
        chk(rx_ready[1] == 1'b1, "R8 enabled", rx_ready[1], 1);
        offer(1, 8'h77);
        chk(rxint_stb == 2'b10, "R8 rxint", rxint_stb, 2);
        chk(rx_ready[1] == 1'b0, "R8 full", rx_ready[1], 0);
        rreg(1, 0, 8'h45, "R8 RR0 avail");
        offer(1, 8'h88);
        chk(rxint_stb == 2'b00, "R8 refused", rxint_stb, 0);
        bus_rd(2'b11, 8'h77, "R8 data read");
        chk(rx_ready[1] == 1'b1, "R8 ready again", rx_ready[1], 1);
        rreg(1, 0, 8'h44, "R8 RR0 cleared");
        offer(1, 8'h88);
        bus_rd(2'b11, 8'h88, "R8 second byte");

        // R5 reset with a held byte
        offer(1, 8'h5E);
        wreg(1, 9, 8'h80);
        rreg(1, 0, 8'h44, "R5 rx cleared");
        chk(rx_ready[1] == 1'b0, "R5 rx disabled", rx_ready[1], 0);

        // R9 swapped map: addr[0] channel, addr[1] type
        @(negedge clk); addr = 2'b01; wdata = 8'h0C; wr2 = 1'b1;
        @(negedge clk); wdata = 8'h33;
        @(negedge clk); wdata = 8'h0C;
        @(negedge clk); wr2 = 1'b0; rd2 = 1'b1;
        @(negedge clk); rd2 = 1'b0;
        chk(rdata2 == 8'h33, "R9 swapped ctrl", rdata2, 8'h33);
        addr = 2'b00; wdata = 8'h0C; wr2 = 1'b1;
        @(negedge clk); wr2 = 1'b0; rd2 = 1'b1;
        @(negedge clk); rd2 = 1'b0;
        chk(rdata2 == 8'h00, "R9 swapped other channel", rdata2, 0);

        repeat (3) @(negedge clk);
        chk(rd_exp_q.size() == 0, "R4 reads drained", rd_exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule